// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two parallel buses, A and B, with one storage register per direction and a per-direction source choice. The A register can sample the A bus and the B register can sample the B bus. The B side is a tri-state output carrying either live A data or the A register. The A side is an open-drain output carrying either live B data or the B register. A width parameter sets the bus size. A polarity parameter picks an inverting or a non-inverting data path. The enclosing logic resolves each bus from separate input, output and drive signals, with pull-ups.

Everything runs on one system clock. The two capture strobes are single-cycle enables sampled on that clock. Each direction has a two-state source machine with states SRC_LIVE and SRC_STORED. The transition GO_STORED fires on a clock edge that samples its select high. The transition GO_LIVE fires on an edge that samples it low. Reset forces both machines to SRC_LIVE. The output multiplexer is steered only by the registered state, so the output always shows a whole source.

With both enables active and both machines in SRC_LIVE, each bus drives the other. When all outside drivers release, the pair holds its last value. With both sides disabled, the buses are isolated and both registers can still be loaded.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a clock edge with `cap_ab`=1 the A register loads `a_in`. On an edge with `cap_ba`=1 the B register loads `b_in`. This happens whatever the selects and enables are. With its strobe low, a register holds its value.
- R2: A select of 0 picks live data and 1 picks stored data. The select takes effect from the clock edge that samples it. In the cycle before that edge the output still shows the old source, complete. From that edge on it shows the new source.
- R3: `b_oe` is 1 exactly while `oe_ab` is 1. `b_out` carries the selected A-to-B data.
- R4: The A side is open-drain. `a_pull_low[i]`=1 pulls line i low, and 0 releases it. A line is pulled low only when `oe_ba_n`=0 and the selected B-to-A data bit is 0. The A side never drives a high.
- R5: With `oe_ab`=0 and `oe_ba_n`=1, neither bus is driven. Both registers still load on their strobes.
- R6: With INVERT=1, data is complemented in both directions, on both the live and the stored paths. With INVERT=0, data passes unchanged.
- R7: Capture samples the bus pins. A register strobed while its bus is driven by this block takes the driven value, so one value can be placed in both registers.
- R8: With both enables active and both sources live, once all outside drivers release, both buses keep their last value.
- R9: Synchronous active-high `rst` clears both registers to zero and puts both source machines in SRC_LIVE.
- R10: With the sources live, both strobes in the same cycle load both registers. In stored mode, loading both registers is done with strobes in separate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Resolved A bus value |
| b_in | input | W | Resolved B bus value |
| cap_ab | input | 1 | Strobe loading the A register from `a_in` |
| cap_ba | input | 1 | Strobe loading the B register from `b_in` |
| sel_ab | input | 1 | A-to-B source request: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source request: 0 live, 1 stored |
| oe_ab | input | 1 | Active-high enable for the B side drive |
| oe_ba_n | input | 1 | Active-low enable for the A side drive |
| b_out | output | W | Value offered to the B bus |
| b_oe | output | 1 | B side drive enable |
| a_pull_low | output | W | Per-line open-drain pull-down for the A bus |

## Verification
The assertions take for granted that the bus inputs settle within the cycle and carry no unknown bits. They also assume that no outside agent drives the B bus while `b_oe` is high. The stimulus releases or matches the outside drivers before turning on the block's own drive. It brings up the live loop in two steps, B side first, so that the wired-AND A bus is never locked low by a stale value. In stored mode it issues the two capture strobes in separate cycles.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Source of the data offered by one direction of the transceiver
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_mode_e;

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (cap_i) begin
            q_r <= bus_i;
        end
    end

    assign q_o = q_r;

endmodule

// File: rtl/xcvr_src_sel.sv
module xcvr_src_sel
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_stored_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    output src_mode_e    mode_o,
    output logic [W-1:0] data_o
);

    src_mode_e state_q, state_d;

    // next-state logic: GO_STORED / GO_LIVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_LIVE:   if (sel_stored_i)  state_d = SRC_STORED;
            SRC_STORED: if (!sel_stored_i) state_d = SRC_LIVE;
            default:    state_d = SRC_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // output: multiplexer steered only by the registered state
    always_comb begin
        data_o = live_i;
        unique case (state_q)
            SRC_LIVE:   data_o = live_i;
            SRC_STORED: data_o = stored_i;
            default:    data_o = live_i;
        endcase
    end

    assign mode_o = state_q;

    // A stored-mode request sampled at an edge leaves the machine in stored mode
    AST_SEL_REGISTERED: assert property (@(posedge clk) disable iff (rst)
        sel_stored_i |=> (mode_o == SRC_STORED)); // R2

endmodule

// File: rtl/xcvr_port_drv.sv
module xcvr_port_drv #(
    parameter int W          = 8,
    parameter bit OPEN_DRAIN = 1'b0,
    parameter bit INVERT     = 1'b0
) (
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] val_o,
    output logic         oe_o
);

    logic [W-1:0] pol_data;

    if (INVERT) begin : g_inv
        assign pol_data = ~data_i;
    end else begin : g_pass
        assign pol_data = data_i;
    end

    if (OPEN_DRAIN) begin : g_od
        // val_o is a pull-low mask: only zeros are ever driven
        assign val_o = en_i ? ~pol_data : '0;
    end else begin : g_pp
        assign val_o = pol_data;
    end

    assign oe_o = en_i;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic [W-1:0] a_pull_low
);

    localparam logic [W-1:0] POL_MASK = INVERT ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] reg_a, reg_b;
    logic [W-1:0] src_ab, src_ba;
    src_mode_e    mode_ab, mode_ba;
    logic         a_oe;

    xcvr_store_reg #(.W(W)) u_reg_a (
        .clk(clk), .rst(rst), .cap_i(cap_ab), .bus_i(a_in), .q_o(reg_a)
    );

    xcvr_store_reg #(.W(W)) u_reg_b (
        .clk(clk), .rst(rst), .cap_i(cap_ba), .bus_i(b_in), .q_o(reg_b)
    );

    xcvr_src_sel #(.W(W)) u_sel_ab (
        .clk(clk), .rst(rst), .sel_stored_i(sel_ab),
        .live_i(a_in), .stored_i(reg_a), .mode_o(mode_ab), .data_o(src_ab)
    );

    xcvr_src_sel #(.W(W)) u_sel_ba (
        .clk(clk), .rst(rst), .sel_stored_i(sel_ba),
        .live_i(b_in), .stored_i(reg_b), .mode_o(mode_ba), .data_o(src_ba)
    );

    xcvr_port_drv #(.W(W), .OPEN_DRAIN(1'b0), .INVERT(INVERT)) u_drv_b (
        .en_i(oe_ab), .data_i(src_ab), .val_o(b_out), .oe_o(b_oe)
    );

    xcvr_port_drv #(.W(W), .OPEN_DRAIN(1'b1), .INVERT(INVERT)) u_drv_a (
        .en_i(!oe_ba_n), .data_i(src_ba), .val_o(a_pull_low), .oe_o(a_oe)
    );

    AST_CAP_TO_B: assert property (@(posedge clk) disable iff (rst)
        (cap_ab && sel_ab && mode_ab == SRC_STORED)
        |=> (b_out == ($past(a_in) ^ POL_MASK))); // R1

    AST_CAP_TO_A: assert property (@(posedge clk) disable iff (rst)
        (cap_ba && sel_ba && mode_ba == SRC_STORED)
        |=> (oe_ba_n || (a_pull_low == ~($past(b_in) ^ POL_MASK)))); // R4

    AST_STORED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cap_ab && sel_ab && mode_ab == SRC_STORED) |=> $stable(b_out)); // R1

    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab && oe_ba_n) |-> (!b_oe && a_pull_low == '0 && !a_oe)); // R5

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;

    localparam int W = 8;

    typedef struct packed {
        logic         ea_en;
        logic [W-1:0] ea;
        logic         eb_en;
        logic [W-1:0] eb;
        logic         cap_ab;
        logic         cap_ba;
        logic         sel_ab;
        logic         sel_ba;
        logic         oe_ab;
        logic         oe_ba_n;
        logic [W-1:0] exp_a;
        logic [W-1:0] exp_b;
    } vec_t;

    // R5 isolation and R10 same-cycle capture, then stored/live transfers, R7 and R8 loop
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h3C, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hA5},
        '{1'b1, 8'h11, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11, 8'h22},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C},
        '{1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h5A},
        '{1'b1, 8'hC3, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC3, 8'hC3},
        '{1'b0, 8'h00, 1'b1, 8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 8'h96},
        '{1'b1, 8'h69, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h69, 8'h69},
        '{1'b1, 8'h69, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h69, 8'h69},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h69, 8'h69},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h69, 8'h69},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h69, 8'h69}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         ea_en = 1'b0, eb_en = 1'b0;
    logic [W-1:0] ea = '0, eb = '0;
    logic         cap_ab = 1'b0, cap_ba = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic         oe_ab = 1'b0, oe_ba_n = 1'b1;
    logic [W-1:0] b_out, a_pull_low, a_bus, b_bus;
    logic         b_oe;

    // bus resolution: A is wired-AND with pull-ups, B is tri-state with pull-ups
    assign a_bus = (ea_en ? ea : {W{1'b1}}) & ~a_pull_low;
    assign b_bus = b_oe ? b_out : (eb_en ? eb : {W{1'b1}});

    bus_xcvr_reg #(.W(W), .INVERT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_bus), .b_in(b_bus),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .b_out(b_out), .b_oe(b_oe), .a_pull_low(a_pull_low)
    );

    // inverting variant, driven directly
    logic [W-1:0] iai = '0, ibi = '0, ibo, iapl;
    logic         icapa = 1'b0, icapb = 1'b0, isab = 1'b0, isba = 1'b0;
    logic         ioeab = 1'b0, ioeban = 1'b1, iboe;

    bus_xcvr_reg #(.W(W), .INVERT(1'b1)) u_dut_inv (
        .clk(clk), .rst(rst), .a_in(iai), .b_in(ibi),
        .cap_ab(icapa), .cap_ba(icapb), .sel_ab(isab), .sel_ba(isba),
        .oe_ab(ioeab), .oe_ba_n(ioeban),
        .b_out(ibo), .b_oe(iboe), .a_pull_low(iapl)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock, then sample 2 ns after the edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: during reset the sources are live whatever the selects ask
        ea_en = 1'b1; ea = 8'h5A; oe_ab = 1'b1; sel_ab = 1'b1;
        cap_ab = 1'b1; cap_ba = 1'b1;
        step(); step();
        chk("R9 live during reset b", b_bus, 8'h5A);
        chk("R9 b_oe follows oe_ab (R3)", {7'b0, b_oe}, 8'h01);
        rst = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
        step();
        chk("R9 cleared A register", b_bus, 8'h00);
        ea_en = 1'b0; sel_ba = 1'b1; oe_ba_n = 1'b0;
        step();
        chk("R9 cleared B register", a_bus, 8'h00);

        for (int i = 0; i < NV; i++) begin
            ea_en = VECS[i].ea_en; ea = VECS[i].ea;
            eb_en = VECS[i].eb_en; eb = VECS[i].eb;
            cap_ab = VECS[i].cap_ab; cap_ba = VECS[i].cap_ba;
            sel_ab = VECS[i].sel_ab; sel_ba = VECS[i].sel_ba;
            oe_ab = VECS[i].oe_ab; oe_ba_n = VECS[i].oe_ba_n;
            step();
            chk($sformatf("R1/R2/R5/R7/R8/R10 vector %0d A bus", i), a_bus, VECS[i].exp_a);
            chk($sformatf("R1/R2/R5/R7/R8/R10 vector %0d B bus", i), b_bus, VECS[i].exp_b);
        end
        cap_ab = 1'b0; cap_ba = 1'b0;

        // R4: open-drain mask, stored B register holds 8'h69
        chk("R4 pull mask", a_pull_low, 8'h96);
        oe_ba_n = 1'b1; #1;
        chk("R4 released when disabled", a_pull_low, 8'h00);
        oe_ab = 1'b0; #1;
        chk("R3 b_oe low", {7'b0, b_oe}, 8'h00);

        // R2: clean switch, A register holds 8'h69
        ea_en = 1'b1; ea = 8'hE7; oe_ab = 1'b1; sel_ab = 1'b1;
        step();
        chk("R2 stored source", b_bus, 8'h69);
        sel_ab = 1'b0; #1;
        chk("R2 old source before edge", b_bus, 8'h69);
        step();
        chk("R2 live after edge", b_bus, 8'hE7);
        sel_ab = 1'b1; #1;
        chk("R2 old live before edge", b_bus, 8'hE7);
        step();
        chk("R2 stored after edge", b_bus, 8'h69);

        // R10 / R7: stored mode, staggered strobes
        ea = 8'h18; cap_ba = 1'b1;
        step();
        cap_ba = 1'b0; cap_ab = 1'b1;
        step();
        cap_ab = 1'b0;
        chk("R10 A register loaded in second cycle", b_bus, 8'h18);
        oe_ab = 1'b0; ea_en = 1'b0; oe_ba_n = 1'b0; sel_ba = 1'b1;
        step();
        chk("R7 B register took driven value", a_bus, 8'h69);

        // R9: mid-run reset
        oe_ba_n = 1'b1; oe_ab = 1'b1; sel_ab = 1'b1;
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk("R9 mid-run reset clears", b_bus, 8'h00);

        // R6: inverting variant
        iai = 8'h0F; icapa = 1'b1; ioeab = 1'b1;
        step();
        chk("R6 inverted live A to B", ibo, 8'hF0);
        icapa = 1'b0; isab = 1'b1; iai = 8'h33;
        step();
        chk("R6 inverted stored A to B", ibo, 8'hF0);
        isab = 1'b0;
        step();
        chk("R6 inverted live new A", ibo, 8'hCC);
        ibi = 8'h55; ioeban = 1'b0;
        step();
        chk("R6 inverted live B to A pull mask", iapl, 8'h55);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule